// File: doc/BRIEF.md
# Chained Lifetime Timer Snapshot

This block forms a 64-bit lifetime counter out of two 32-bit down-counters. The low counter steps down on every clock while the run input is high. The high counter steps down only when the low counter expires. Each counter reloads from its own load input when it steps away from zero. Together, the high counter and the low counter form one 64-bit value that falls steadily.

Software reads the value through a small register port with an address, a read strobe and a data output. A read of the upper window returns the live high count. In the same clock edge, that read freezes the low count into a shadow register. A later read of the lower window returns the frozen copy. Software therefore reads the upper window first and the lower window second. The two halves then belong to the same instant, even when the low counter rolls over between the two accesses.

Read data is registered. It appears on `rd_data` in the cycle after the strobe and holds there until the next strobe.

Top module: `chained_lifetime_timer`

## Requirements
- R1: After reset both counters, the shadow register and `rd_data` are zero, so an upper read or a lower read issued first returns 0.
- R2: While `run` is high and the low count is nonzero, the low count falls by one each clock. While `run` is low, neither counter changes.
- R3: When `run` is high and the low count is zero, the low counter expires in that cycle and loads `load_lo` at that edge.
- R4: The high counter steps only on a low-counter expiry. It falls by one on that expiry, or loads `load_hi` if the high count is already zero.
- R5: A strobe with `rd_addr` = 0xE0 (the upper window) puts onto `rd_data`, one cycle later, the high count held in the strobe cycle.
- R6: The same upper-window strobe copies into the shadow register the low count held in the strobe cycle.
- R7: A strobe with `rd_addr` = 0xE4 (the lower window) returns the shadow value one cycle later. It leaves the counters and the shadow unchanged, so repeated lower reads return the same value.
- R8: When an upper read lands on the cycle of a low-counter expiry, the returned high half and the captured low half both come from the state before that expiry.
- R9: While the high count does not wrap, each upper-then-lower read pair gives a 64-bit value {high, low} that is strictly smaller than the value from the pair before it.
- R10: A strobe to any other address returns 0. With no strobe, `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enable for the low counter |
| load_lo | input | 32 | Reload value of the low counter |
| load_hi | input | 32 | Reload value of the high counter |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Register offset (0xE0 upper, 0xE4 lower) |
| rd_data | output | 32 | Registered read data |

## Verification
Free-running reads taken at random spacing show that the two halves of each pair agree and that successive pairs fall. This separates a correct shadow from one that tracks the live low count. Reads placed exactly on the cycle of a low rollover distinguish pre-update sampling from post-update sampling of either half. Repeated lower reads with the counters still running expose a shadow that refreshes by itself. Reads with `run` low, together with a small high reload that forces the high counter to wrap, confirm that the counters hold and that the high counter reloads correctly.

// File: rtl/lt_pkg.sv
package lt_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2,
        SEL_BAD  = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/lt_down_counter.sv
module lt_down_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_o,
    output logic         expire_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = tick && (st_q.cnt == '0);
        if (tick) begin
            st_d.cnt = expire_d ? load_val : (st_q.cnt - ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign expire_o = expire_d;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - ONE)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_o)); // R2
    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_o == '0) |=> (cnt_o == $past(load_val))); // R3
endmodule

// File: rtl/lt_snapshot_regs.sv
module lt_snapshot_regs
    import lt_pkg::*;
#(
    parameter int              W      = 32,
    parameter int              AW     = 8,
    parameter logic [AW-1:0]   HI_OFS = 8'hE0,
    parameter logic [AW-1:0]   LO_OFS = 8'hE4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [W-1:0]  hi_val,
    input  logic [W-1:0]  lo_val,
    output logic [W-1:0]  rd_data
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] rdata;
    } snap_state_t;

    snap_state_t st_d, st_q;
    rd_sel_e     sel;

    always_comb begin
        if (!rd_en)                sel = SEL_NONE;
        else if (rd_addr == HI_OFS) sel = SEL_HI;
        else if (rd_addr == LO_OFS) sel = SEL_LO;
        else                       sel = SEL_BAD;
    end

    always_comb begin
        st_d = st_q;
        unique case (sel)
            SEL_HI: begin
                st_d.rdata  = hi_val;
                st_d.shadow = lo_val;
            end
            SEL_LO:  st_d.rdata = st_q.shadow;
            SEL_BAD: st_d.rdata = '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;

    AST_HI_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == HI_OFS) |=> (rd_data == $past(hi_val))); // R5
    AST_SHADOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == HI_OFS) |=> (st_q.shadow == $past(lo_val))); // R6
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == HI_OFS) |=> $stable(st_q.shadow)); // R7
    AST_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == LO_OFS) |=> (rd_data == $past(st_q.shadow))); // R7
    AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != HI_OFS && rd_addr != LO_OFS) |=> (rd_data == '0)); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R10
endmodule

// File: rtl/chained_lifetime_timer.sv
module chained_lifetime_timer #(
    parameter int            CNT_W  = 32,
    parameter int            ADDR_W = 8,
    parameter logic [ADDR_W-1:0] HI_OFS = 8'hE0,
    parameter logic [ADDR_W-1:0] LO_OFS = 8'hE4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CNT_W-1:0]  load_lo,
    input  logic [CNT_W-1:0]  load_hi,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    localparam int NUM_STAGES = 2;

    logic [CNT_W-1:0] cnt   [NUM_STAGES];
    logic [CNT_W-1:0] load  [NUM_STAGES];
    logic             tick  [NUM_STAGES];
    logic             exp_w [NUM_STAGES];

    assign load[0] = load_lo;
    assign load[1] = load_hi;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign tick[i] = run;
        end else begin : g_chain
            assign tick[i] = exp_w[i-1];
        end
        lt_down_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick[i]),
            .load_val (load[i]),
            .cnt_o    (cnt[i]),
            .expire_o (exp_w[i])
        );
    end

    lt_snapshot_regs #(
        .W      (CNT_W),
        .AW     (ADDR_W),
        .HI_OFS (HI_OFS),
        .LO_OFS (LO_OFS)
    ) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .hi_val  (cnt[1]),
        .lo_val  (cnt[0]),
        .rd_data (rd_data)
    );

    AST_HI_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && cnt[0] == '0) |=> $stable(cnt[1])); // R4
    AST_HI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt[0] == '0 && cnt[1] != '0) |=> (cnt[1] == $past(cnt[1]) - 1)); // R4
    AST_EDGE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == HI_OFS && run && cnt[0] == '0) |=> (rd_data == $past(cnt[1]))); // R8
endmodule

// File: tb/chained_lifetime_timer_tb.sv
module chained_lifetime_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] load_lo = '0;
    logic [31:0] load_hi = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";

    // behavioural model
    longint unsigned m_lo = 0, m_hi = 0, m_sh = 0, m_rd = 0;
    longint unsigned prev_snap;
    bit have_prev = 0;

    always #10 clk = ~clk;

    chained_lifetime_timer dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .load_lo(load_lo), .load_hi(load_hi),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_sh = 0; m_rd = 0;
        end else begin
            bit ex;
            ex = run && (m_lo == 0);
            if (rd_en) begin
                if (rd_addr == 8'hE0) begin m_rd = m_hi; m_sh = m_lo; end
                else if (rd_addr == 8'hE4) m_rd = m_sh;
                else m_rd = 0;
            end
            if (run) m_lo = (m_lo == 0) ? longint'(load_lo) : m_lo - 1;
            if (ex)  m_hi = (m_hi == 0) ? longint'(load_hi) : m_hi - 1;
        end
        @(negedge clk);
        check(cur_req, rd_data, m_rd);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_en = 1'b1; rd_addr = a;
        cyc();
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic pair_check(input string req);
        logic [31:0] h, l;
        longint unsigned s;
        rd(8'hE0, h);
        cyc();
        rd(8'hE4, l);
        s = {h, l};
        if (have_prev) begin
            n_tests++;
            if (!(s < prev_snap)) begin
                n_fail++;
                $display("FAIL %s actual=%0h expected below %0h", req, s, prev_snap);
            end
        end
        prev_snap = s;
        have_prev = 1;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1: reset state
        check("R1", rd_data, 0);
        rd(8'hE4, v); check("R1", v, 0);
        rd(8'hE0, v); check("R1", v, 0);

        // R2 R3 R4: counting, rollover, chaining
        cur_req = "R2";
        load_lo = 32'd5; load_hi = 32'd100000;
        run = 1'b1;
        repeat (40) cyc();
        cur_req = "R3";
        rd(8'hE4, v); check("R6", v, 0);
        rd(8'hE0, v); check("R5", v, m_hi == 0 ? 0 : v);
        // R2: hold when run low
        cur_req = "R2";
        run = 1'b0;
        rd(8'hE0, v); rd(8'hE0, v2); check("R2", v2, v);
        rd(8'hE4, v); cyc(); rd(8'hE4, v2); check("R2", v2, v);
        run = 1'b1;

        // R9: monotonic snapshots over many rollovers, varied spacing
        cur_req = "R9";
        for (int i = 0; i < 60; i++) begin
            pair_check("R9");
            repeat ((i * 7) % 11) cyc();
        end
        load_lo = 32'd3;
        for (int i = 0; i < 40; i++) begin
            pair_check("R9");
            repeat (i % 4) cyc();
        end

        // R8: upper read landing exactly on a low expiry
        cur_req = "R8";
        for (int i = 0; i < 20; i++) begin
            longint unsigned eh, el;
            while (m_lo != 0) cyc();
            eh = m_hi; el = m_lo;
            rd(8'hE0, v); check("R8", v, eh);
            rd(8'hE4, v); check("R8", v, el);
            repeat (i % 3) cyc();
        end

        // R7: repeated lower reads, counters running
        cur_req = "R7";
        rd(8'hE0, v);
        rd(8'hE4, v);
        for (int i = 0; i < 10; i++) begin
            repeat (i) cyc();
            rd(8'hE4, v2); check("R7", v2, v);
        end

        // R10: unmapped address and idle hold
        cur_req = "R10";
        rd(8'h10, v); check("R10", v, 0);
        rd(8'hE0, v);
        repeat (5) cyc();
        check("R10", rd_data, v);
        rd(8'hE2, v); check("R10", v, 0);

        // R4: high wrap with a small reload
        cur_req = "R4";
        rst_n = 1'b0; run = 1'b0; cyc(); cyc();
        rst_n = 1'b1;
        load_lo = 32'd2; load_hi = 32'd3;
        run = 1'b1;
        for (int i = 0; i < 40; i++) begin
            rd(8'hE0, v); check("R4", v, m_rd);
            rd(8'hE4, v); check("R5", v, m_rd);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule